// File: doc/BRIEF.md
# Cache Range Maintenance Splitter

This block takes one cache maintenance request and turns it into a paced series of commands for a level-2 cache controller. A request names an operation (invalidate, clean or flush), a byte start address and an exclusive byte end address. The block walks the span in chunks. Each chunk is at most a set number of bytes and never crosses a page. For every chunk it issues range commands that each carry an inclusive, line-aligned start and end. Lines at the edges that are only partly covered get single-line commands.

Every command is held on the command port until the cache acknowledges it, and the next command follows in the cycle after the acknowledge. A range command is sent as a start write followed at once by an end write. When the cache is forced to write-through, cleaning is pointless, so no clean commands are sent. Every request ends with a barrier command. Once the barrier is acknowledged, a one-cycle done pulse is raised.

Top module: `cache_range_splitter`

## Requirements
- R1: After reset, req_ready_o is 1, cmd_valid_o is 0 and done_o is 0.
- R2: Operation codes: 0 = invalidate, 1 = clean, 2 = flush, and 3 behaves as flush. For clean and flush, the start is rounded down and the end is rounded up to 32-byte line boundaries. Every command except the barrier carries a line-aligned address.
- R3: A chunk ends at the smallest of three addresses: the request end, the chunk start plus 1024, and the next 4096-byte page boundary. The end write of a range carries the chunk end minus 32.
- R4: Command kinds are 0 = line clean-and-invalidate, 1 = clean range start, 2 = clean range end, 3 = invalidate range start, 4 = invalidate range end and 5 = barrier (address 0). A range start write is always followed directly by its end write.
- R5: For invalidate, an unaligned start first gets kind 0 on its containing line and the start is rounded up. An unaligned end then gets kind 0 on its containing line and the end is rounded down. Only whole lines in between are range-invalidated.
- R6: For flush, each chunk gets a clean range pair followed by an invalidate range pair over the same span.
- R7: With wt_override_i set at acceptance, a clean request issues only the barrier, and a flush issues only invalidate pairs.
- R8: The barrier is the last command of every request. done_o pulses for exactly one cycle, in the cycle after the barrier is acknowledged.
- R9: A command holds kind and address stable until cmd_ack_i is sampled high. The next command is presented in the following cycle.
- R10: A request is taken only when req_ready_o is 1, and no command is presented while it is 1. Request inputs that change while busy have no effect on the command stream.
- R11: When no whole line remains after edge handling, no range command is issued. If both edges of an invalidate fall in the same line, that line gets two kind-0 commands.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_valid_i | input | 1 | Request present |
| req_op_i | input | 2 | Operation code |
| req_start_i | input | AW | Byte start address |
| req_end_i | input | AW | Exclusive byte end address |
| wt_override_i | input | 1 | Cache forced write-through |
| req_ready_o | output | 1 | Idle, request accepted |
| cmd_valid_o | output | 1 | Command presented |
| cmd_kind_o | output | 3 | Command kind |
| cmd_addr_o | output | AW | Command address |
| cmd_ack_i | input | 1 | Command acknowledged |
| done_o | output | 1 | Request finished pulse |

## Verification
A wrong chunk pointer, a wrong limit or a wrong state-machine state shows up on the very next command after an acknowledge, as a wrong kind or address. The bench compares every command with a list computed from the requirements, so a fault is reported within one handshake. Acknowledge delays are varied and request inputs are toggled while busy, to expose commands that are not held stable and requests that leak in. Directed cases cover page crossings, exact 1024-byte chunks, edges that share a line, empty spans and both write-through cases.

// File: rtl/cache_split_pkg.sv
package cache_split_pkg;
  typedef enum logic [1:0] {
    OP_INV   = 2'd0,
    OP_CLEAN = 2'd1,
    OP_FLUSH = 2'd2
  } maint_op_e;

  typedef enum logic [2:0] {
    K_LINE_CI = 3'd0,
    K_CLN_S   = 3'd1,
    K_CLN_E   = 3'd2,
    K_INV_S   = 3'd3,
    K_INV_E   = 3'd4,
    K_BAR     = 3'd5
  } cmd_kind_e;

  typedef enum logic [2:0] {
    S_IDLE, S_HEAD, S_TAIL, S_CS, S_CE, S_IS, S_IE, S_BAR
  } split_state_e;
endpackage

// File: rtl/csplit_prep.sv
module csplit_prep
  import cache_split_pkg::*;
#(
  parameter int AW         = 32,
  parameter int LINE_BYTES = 32
) (
  input  logic [1:0]    op_i,
  input  logic [AW-1:0] start_i,
  input  logic [AW-1:0] end_i,
  input  logic          wt_i,
  output logic          head_need_o,
  output logic          tail_need_o,
  output logic [AW-1:0] head_addr_o,
  output logic [AW-1:0] tail_addr_o,
  output logic [AW:0]   cur_o,
  output logic [AW:0]   lim_o,
  output logic          cln_o,
  output logic          inv_o
);
  localparam int EW = AW + 1;
  localparam int LG = $clog2(LINE_BYTES);
  localparam logic [AW:0] LMASK = EW'(LINE_BYTES - 1);

  logic          inv_only;
  logic [AW:0]   s_dn, e_dn, e_up;

  always_comb begin
    inv_only    = (op_i == OP_INV);
    s_dn        = {1'b0, start_i} & ~LMASK;
    e_dn        = {1'b0, end_i} & ~LMASK;
    e_up        = ({1'b0, end_i} + LMASK) & ~LMASK;
    head_need_o = inv_only && (|start_i[LG-1:0]);
    tail_need_o = inv_only && (|end_i[LG-1:0]);
    head_addr_o = s_dn[AW-1:0];
    tail_addr_o = e_dn[AW-1:0];
    cur_o       = head_need_o ? s_dn + EW'(LINE_BYTES) : s_dn;
    lim_o       = inv_only ? e_dn : e_up;
    cln_o       = !inv_only && !wt_i;
    inv_o       = (op_i != OP_CLEAN);
  end
endmodule

// File: rtl/csplit_chunk.sv
module csplit_chunk #(
  parameter int AW         = 32,
  parameter int LINE_BYTES = 32,
  parameter int MAX_BYTES  = 1024,
  parameter int PAGE_BYTES = 4096
) (
  input  logic [AW:0] cur_i,
  input  logic [AW:0] lim_i,
  output logic [AW:0] chunk_end_o,
  output logic [AW:0] last_line_o,
  output logic        work_o,
  output logic        more_o
);
  localparam int EW = AW + 1;

  logic [AW:0] by_max, by_page, cap;

  always_comb begin
    by_max      = cur_i + EW'(MAX_BYTES);
    by_page     = (cur_i | EW'(PAGE_BYTES - 1)) + EW'(1);
    cap         = (by_max < by_page) ? by_max : by_page;
    chunk_end_o = (lim_i < cap) ? lim_i : cap;
    last_line_o = chunk_end_o - EW'(LINE_BYTES);
    work_o      = cur_i < lim_i;
    more_o      = chunk_end_o < lim_i;
  end
endmodule

// File: rtl/csplit_cmd_mux.sv
module csplit_cmd_mux
  import cache_split_pkg::*;
#(
  parameter int AW = 32
) (
  input  split_state_e  state_i,
  input  logic [AW-1:0] head_addr_i,
  input  logic [AW-1:0] tail_addr_i,
  input  logic [AW-1:0] cur_i,
  input  logic [AW-1:0] last_i,
  output logic          valid_o,
  output logic [2:0]    kind_o,
  output logic [AW-1:0] addr_o
);
  always_comb begin
    valid_o = (state_i != S_IDLE);
    kind_o  = K_BAR;
    addr_o  = '0;
    unique case (state_i)
      S_HEAD:  begin kind_o = K_LINE_CI; addr_o = head_addr_i; end
      S_TAIL:  begin kind_o = K_LINE_CI; addr_o = tail_addr_i; end
      S_CS:    begin kind_o = K_CLN_S;   addr_o = cur_i;       end
      S_CE:    begin kind_o = K_CLN_E;   addr_o = last_i;      end
      S_IS:    begin kind_o = K_INV_S;   addr_o = cur_i;       end
      S_IE:    begin kind_o = K_INV_E;   addr_o = last_i;      end
      default: begin kind_o = K_BAR;     addr_o = '0;          end
    endcase
  end
endmodule

// File: rtl/cache_range_splitter.sv
module cache_range_splitter
  import cache_split_pkg::*;
#(
  parameter int AW         = 32,
  parameter int LINE_BYTES = 32,
  parameter int MAX_BYTES  = 1024,
  parameter int PAGE_BYTES = 4096
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          req_valid_i,
  input  logic [1:0]    req_op_i,
  input  logic [AW-1:0] req_start_i,
  input  logic [AW-1:0] req_end_i,
  input  logic          wt_override_i,
  output logic          req_ready_o,
  output logic          cmd_valid_o,
  output logic [2:0]    cmd_kind_o,
  output logic [AW-1:0] cmd_addr_o,
  input  logic          cmd_ack_i,
  output logic          done_o
);
  localparam int LG = $clog2(LINE_BYTES);
  localparam int PG = $clog2(PAGE_BYTES);

  split_state_e  state_q, state_d;
  logic [AW-1:0] head_addr_q, tail_addr_q;
  logic [AW:0]   cur_q, lim_q;
  logic          tail_q, cln_q, inv_q, done_q;

  logic          p_head, p_tail, p_cln, p_inv;
  logic [AW-1:0] p_head_addr, p_tail_addr;
  logic [AW:0]   p_cur, p_lim;
  logic [AW:0]   chunk_end, last_line;
  logic          work, more, accept;

  csplit_prep #(.AW(AW), .LINE_BYTES(LINE_BYTES)) u_prep (
    .op_i(req_op_i), .start_i(req_start_i), .end_i(req_end_i), .wt_i(wt_override_i),
    .head_need_o(p_head), .tail_need_o(p_tail),
    .head_addr_o(p_head_addr), .tail_addr_o(p_tail_addr),
    .cur_o(p_cur), .lim_o(p_lim), .cln_o(p_cln), .inv_o(p_inv)
  );

  csplit_chunk #(.AW(AW), .LINE_BYTES(LINE_BYTES), .MAX_BYTES(MAX_BYTES),
                 .PAGE_BYTES(PAGE_BYTES)) u_chunk (
    .cur_i(cur_q), .lim_i(lim_q), .chunk_end_o(chunk_end),
    .last_line_o(last_line), .work_o(work), .more_o(more)
  );

  csplit_cmd_mux #(.AW(AW)) u_mux (
    .state_i(state_q), .head_addr_i(head_addr_q), .tail_addr_i(tail_addr_q),
    .cur_i(cur_q[AW-1:0]), .last_i(last_line[AW-1:0]),
    .valid_o(cmd_valid_o), .kind_o(cmd_kind_o), .addr_o(cmd_addr_o)
  );

  function automatic split_state_e pick(input logic w, input logic c, input logic i);
    if (w && c)      return S_CS;
    else if (w && i) return S_IS;
    else             return S_BAR;
  endfunction

  assign req_ready_o = (state_q == S_IDLE);
  assign accept      = req_ready_o && req_valid_i;
  assign done_o      = done_q;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      S_IDLE: if (accept) begin
        if (p_head)      state_d = S_HEAD;
        else if (p_tail) state_d = S_TAIL;
        else             state_d = pick(p_cur < p_lim, p_cln, p_inv);
      end
      S_HEAD: if (cmd_ack_i) state_d = tail_q ? S_TAIL : pick(work, cln_q, inv_q);
      S_TAIL: if (cmd_ack_i) state_d = pick(work, cln_q, inv_q);
      S_CS:   if (cmd_ack_i) state_d = S_CE;
      S_CE:   if (cmd_ack_i) state_d = inv_q ? S_IS : pick(more, cln_q, inv_q);
      S_IS:   if (cmd_ack_i) state_d = S_IE;
      S_IE:   if (cmd_ack_i) state_d = pick(more, cln_q, inv_q);
      S_BAR:  if (cmd_ack_i) state_d = S_IDLE;
      default: state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= S_IDLE;
      head_addr_q <= '0;
      tail_addr_q <= '0;
      cur_q       <= '0;
      lim_q       <= '0;
      tail_q      <= 1'b0;
      cln_q       <= 1'b0;
      inv_q       <= 1'b0;
      done_q      <= 1'b0;
    end else begin
      state_q <= state_d;
      done_q  <= (state_q == S_BAR) && cmd_ack_i;
      if (accept) begin
        head_addr_q <= p_head_addr;
        tail_addr_q <= p_tail_addr;
        cur_q       <= p_cur;
        lim_q       <= p_lim;
        tail_q      <= p_tail;
        cln_q       <= p_cln;
        inv_q       <= p_inv;
      end else if (cmd_ack_i && ((state_q == S_IE) || (state_q == S_CE && !inv_q))) begin
        cur_q <= chunk_end;
      end
    end
  end

  // R10: idle means no command on the port
  p_idle_quiet_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_ready_o |-> !cmd_valid_o);

  p_line_aligned_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_valid_o && cmd_kind_o != K_BAR) |-> (cmd_addr_o[LG-1:0] == '0));

  // R3: range end inside the chunk's page and size cap
  p_chunk_cap_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_valid_o && (cmd_kind_o == K_CLN_E || cmd_kind_o == K_INV_E)) |->
      (cmd_addr_o >= cur_q[AW-1:0]) &&
      ((cmd_addr_o - cur_q[AW-1:0]) < AW'(MAX_BYTES)) &&
      (cmd_addr_o[AW-1:PG] == cur_q[AW-1:PG]));

  p_clean_pair_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_valid_o && cmd_ack_i && cmd_kind_o == K_CLN_S) |=>
      (cmd_valid_o && cmd_kind_o == K_CLN_E));

  p_inv_pair_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_valid_o && cmd_ack_i && cmd_kind_o == K_INV_S) |=>
      (cmd_valid_o && cmd_kind_o == K_INV_E));

  p_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_valid_o && !cmd_ack_i) |=>
      (cmd_valid_o && $stable(cmd_kind_o) && $stable(cmd_addr_o)));

  p_done_after_bar_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> $past(cmd_valid_o && cmd_ack_i && cmd_kind_o == K_BAR));

  p_done_pulse_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
endmodule

// File: tb/sim_cache_range_splitter.sv
module sim_cache_range_splitter;
  localparam int CLK_PERIOD = 10;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req_valid_i = 1'b0;
  logic [1:0]  req_op_i = '0;
  logic [31:0] req_start_i = '0;
  logic [31:0] req_end_i = '0;
  logic        wt_override_i = 1'b0;
  logic        cmd_ack_i = 1'b0;
  logic        req_ready_o, cmd_valid_o, done_o;
  logic [2:0]  cmd_kind_o;
  logic [31:0] cmd_addr_o;

  int n_chk = 0;
  int n_bad = 0;

  logic [2:0]  exp_kind [64];
  logic [31:0] exp_addr [64];
  int          n_exp;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  cache_range_splitter u0 (
    .clk_i(clk_i), .rst_ni(rst_ni), .req_valid_i(req_valid_i), .req_op_i(req_op_i),
    .req_start_i(req_start_i), .req_end_i(req_end_i), .wt_override_i(wt_override_i),
    .req_ready_o(req_ready_o), .cmd_valid_o(cmd_valid_o), .cmd_kind_o(cmd_kind_o),
    .cmd_addr_o(cmd_addr_o), .cmd_ack_i(cmd_ack_i), .done_o(done_o)
  );

  task automatic chk(input string req, input logic ok, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic push(input logic [2:0] k, input longint a);
    exp_kind[n_exp] = k;
    exp_addr[n_exp] = a[31:0];
    n_exp++;
  endtask

  // expected stream from R2..R8, R11
  task automatic build_exp(input logic [1:0] op, input longint s, input longint e, input logic wt);
    longint cur, lim, ce, pg;
    logic cln, inv;
    n_exp = 0;
    if (op == 2'd0) begin
      if (s % 32 != 0) begin push(3'd0, s & ~64'd31); cur = (s | 31) + 1; end
      else cur = s;
      if (e % 32 != 0) push(3'd0, e & ~64'd31);
      lim = e & ~64'd31;
    end else begin
      cur = s & ~64'd31;
      lim = (e + 31) & ~64'd31;
    end
    cln = (op != 2'd0) && !wt;
    inv = (op != 2'd1);
    if (cln || inv) begin
      while (cur < lim) begin
        ce = lim;
        if (cur + 1024 < ce) ce = cur + 1024;
        pg = (cur | 4095) + 1;
        if (pg < ce) ce = pg;
        if (cln) begin push(3'd1, cur); push(3'd2, ce - 32); end
        if (inv) begin push(3'd3, cur); push(3'd4, ce - 32); end
        cur = ce;
      end
    end
    push(3'd5, 0);
  endtask

  task automatic run_req(input logic [1:0] op, input logic [31:0] s, input logic [31:0] e,
                         input logic wt);
    build_exp(op, longint'(s), longint'(e), wt);
    @(negedge clk_i);
    chk("R10 ready before request", req_ready_o === 1'b1 && cmd_valid_o === 1'b0,
        {req_ready_o, cmd_valid_o}, 2'b10);
    req_valid_i = 1'b1; req_op_i = op; req_start_i = s; req_end_i = e; wt_override_i = wt;
    @(negedge clk_i);
    for (int i = 0; i < n_exp; i++) begin
      int w = 0;
      int dly;
      while (!cmd_valid_o && w < 20) begin
        req_valid_i = 1'b0;
        @(negedge clk_i);
        w++;
      end
      chk(exp_kind[i] == 3'd0 ? "R5 edge line command" :
          (exp_kind[i] == 3'd5 ? "R8 barrier" : "R3 R4 R6 range command"),
          cmd_valid_o === 1'b1 && cmd_kind_o === exp_kind[i] && cmd_addr_o === exp_addr[i],
          {cmd_kind_o, cmd_addr_o}, {exp_kind[i], exp_addr[i]});
      dly = $urandom_range(0, 2);
      for (int d = 0; d < dly; d++) begin
        // R10: disturb request inputs while busy
        req_valid_i = 1'($urandom_range(0, 1));
        req_op_i = 2'($urandom_range(0, 3));
        req_start_i = $urandom; req_end_i = $urandom;
        wt_override_i = 1'($urandom_range(0, 1));
        @(negedge clk_i);
        chk("R9 R10 command held", cmd_valid_o === 1'b1 && cmd_kind_o === exp_kind[i] &&
            cmd_addr_o === exp_addr[i], {cmd_kind_o, cmd_addr_o}, {exp_kind[i], exp_addr[i]});
      end
      req_valid_i = 1'b0;
      cmd_ack_i = 1'b1;
      @(negedge clk_i);
      cmd_ack_i = 1'b0;
    end
    chk("R8 done after barrier ack", done_o === 1'b1 && req_ready_o === 1'b1,
        {done_o, req_ready_o}, 2'b11);
    @(negedge clk_i);
    chk("R8 done is one cycle", done_o === 1'b0 && cmd_valid_o === 1'b0,
        {done_o, cmd_valid_o}, 2'b00);
  endtask

  initial begin
    repeat (150000) @(posedge clk_i);
    n_bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk_i);
    chk("R1 reset state", req_ready_o === 1'b1 && cmd_valid_o === 1'b0 && done_o === 1'b0,
        {req_ready_o, cmd_valid_o, done_o}, 3'b100);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk("R1 idle after reset", req_ready_o === 1'b1 && cmd_valid_o === 1'b0 && done_o === 1'b0,
        {req_ready_o, cmd_valid_o, done_o}, 3'b100);

    run_req(2'd0, 32'h0000_1005, 32'h0000_1FEA, 1'b0); // R5 both edges
    run_req(2'd0, 32'h0000_2000, 32'h0000_2400, 1'b0); // R3 exact 1024
    run_req(2'd1, 32'h0000_0FC4, 32'h0000_1044, 1'b0); // R2 R3 page crossing
    run_req(2'd0, 32'h0000_3105, 32'h0000_310A, 1'b0); // R11 same line
    run_req(2'd2, 32'h0000_4000, 32'h0000_4000, 1'b0); // R11 empty
    run_req(2'd1, 32'h0000_5000, 32'h0000_6000, 1'b1); // R7 clean skipped
    run_req(2'd2, 32'h0000_5010, 32'h0000_5830, 1'b1); // R7 flush invalidates only
    run_req(2'd3, 32'h0000_7FF0, 32'h0000_8900, 1'b0); // R2 op 3, R6
    run_req(2'd0, 32'h0000_9000, 32'h0000_9C00, 1'b0); // R3 three chunks
    run_req(2'd2, 32'h0000_A3E1, 32'h0000_A3E2, 1'b0); // R6 single line

    for (int n = 0; n < 60; n++) begin
      logic [31:0] s;
      logic [31:0] len;
      s   = $urandom & 32'h00FF_FFFF;
      len = $urandom_range(0, 5000);
      run_req(2'($urandom_range(0, 3)), s, s + len, 1'($urandom_range(0, 1)));
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule